// File: doc/BRIEF.md
# Register Access Command Handler for a Single-Wire Slave

This block sits behind the device-selection logic of a single-wire (1-Wire) slave. Once the device has been selected, it takes over the bit stream. Bits come in through an abstract slot interface: a one-cycle strobe carries each received bit, and a one-cycle request takes the next bit the slave is to send. The handler decodes a function opcode and a start address. It then streams data bytes, least significant bit first, out of or into a 256-location byte space. The address advances after every complete byte and wraps from FFh back to 00h.

The byte space holds four registers:
- a status register with a sleep-enable bit and an address-opcode-select bit;
- a feature register whose bit 6 controls and senses an open-drain general-purpose pin;
- a read-only 16-bit current value, supplied from outside;
- a read/write 16-bit accumulator. A write to it is handed to the measurement logic as a one-cycle strobe that carries the full 16-bit value.

When a read reaches the high byte of a two-byte value, both bytes are captured and held for the rest of the command, so the two halves always match. A bus reset ends any command at any bit. A byte cut short by the reset is discarded.

States, all defined in the sequencer:
- IDLE waits for the selection pulse and goes to OPCODE.
- OPCODE collects eight bits. A read or write opcode leads to ADDRESS. Any other opcode leads to SKIP.
- ADDRESS collects eight bits and goes to READ or WRITE, depending on the opcode.
- READ, WRITE and SKIP stay where they are until a bus reset.
- A bus reset returns every state to IDLE.

Top module: `owreg_cmd`

## Requirements
- R1: After `sel_start`, the first eight received bits form the opcode. 69h selects a read and 6Ch selects a write; in both cases the next eight bits form the start address. Any other opcode makes the block ignore all further bits until `bus_reset`.
- R2: All bytes are carried least significant bit first. For a read, `tx_bit` holds bit 0 of the first data byte from the cycle after the strobe of the last address bit. Each `tx_req` strobe moves on to the next bit.
- R3: The address increments after every complete byte, in both directions, and wraps from FFh to 00h.
- R4: When a read reaches 0Eh or 10h, both bytes of that 16-bit value are captured. For the rest of the command, both bytes are read from the captured copy. A low byte reached without its high byte being read first shows the live value.
- R5: The status register is at 01h. Bit 6 is sleep enable (`sleep_en`) and bit 4 is the address-opcode select (`opsel`). Both reset to 0, both are writable, and every other bit reads 0.
- R6: The feature register is at 08h. Writing 0 to bit 6 asserts `pio_drive_low`, and writing 1 releases it; after reset the pin is released. A read returns `pio_pin_in` at bit 6, with the other bits 0.
- R7: The current value is read-only. Its high byte is at 0Eh and its low byte at 0Fh, and writes to these addresses are ignored.
- R8: The accumulator has its high byte at 10h and its low byte at 11h. A complete byte written to 11h pulses `acc_wr_en` for one cycle, in the cycle after the strobe of the last bit. The `acc_wr_data` it carries is {high byte written earlier in the same command, or `acc_val[15:8]` if none was written, new low byte}.
- R9: Reserved addresses (every address other than 01h, 08h, 0Eh, 0Fh, 10h and 11h) read as 00h, and writes to them are ignored.
- R10: `bus_reset` ends any command at any bit and returns the block to waiting for `sel_start`. A byte that is incomplete when the reset arrives is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | Bus reset pulse, ends the current command |
| sel_start | input | 1 | Device selected, function phase begins |
| rx_valid | input | 1 | Received-bit strobe |
| rx_bit | input | 1 | Value of received bit |
| tx_req | input | 1 | Strobe: current transmit bit consumed |
| tx_bit | output | 1 | Bit to transmit (1 when not reading) |
| cur_val | input | 16 | Live current value |
| acc_val | input | 16 | Live accumulator value |
| pio_pin_in | input | 1 | Sensed level of the general-purpose pin |
| pio_drive_low | output | 1 | Enables the open-drain pull-down |
| sleep_en | output | 1 | Status bit 6 |
| opsel | output | 1 | Status bit 4 |
| acc_wr_en | output | 1 | One-cycle accumulator write strobe |
| acc_wr_data | output | 16 | Value committed to the accumulator |

## Verification
Register writes (status, feature) become visible on the outputs one cycle after the strobe that carries the eighth bit of the byte. `acc_wr_en` rises in that same cycle and lasts exactly one cycle. Read data is combinational from registered address and bit-index state, so `tx_bit` is valid from the cycle after the last address strobe, and after each `tx_req`. The bench drives every strobe on a falling edge and holds it for one full cycle. It samples outputs on the falling edge after the relevant rising edge, and it counts accumulator strobes in a monitor at each rising edge.

// File: rtl/owreg_pkg.sv
package owreg_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam int WORD_W = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] OP_READ  = 8'h69;
    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h6C;

    localparam logic [BYTE_W-1:0] A_STATUS = 8'h01;
    localparam logic [BYTE_W-1:0] A_FEAT   = 8'h08;
    localparam logic [BYTE_W-1:0] A_CUR_HI = 8'h0E;
    localparam logic [BYTE_W-1:0] A_CUR_LO = 8'h0F;
    localparam logic [BYTE_W-1:0] A_ACC_HI = 8'h10;
    localparam logic [BYTE_W-1:0] A_ACC_LO = 8'h11;

    localparam int B_SLEEP = 6;
    localparam int B_OPSEL = 4;
    localparam int B_PIO   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDRESS,
        ST_READ,
        ST_WRITE,
        ST_SKIP
    } seq_state_t;
endpackage

// File: rtl/owreg_seq.sv
module owreg_seq
    import owreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              sel_start,
    input  logic              rx_valid,
    input  logic              rx_bit,
    input  logic              tx_req,
    output logic [BYTE_W-1:0] addr,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              rd_active,
    output logic              wr_active,
    output logic              wr_commit,
    output logic [BYTE_W-1:0] wr_byte
);
    seq_state_t        st, st_nxt;
    logic [BYTE_W-1:0] shreg;
    logic              is_wr;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              last_bit;

    assign last_bit  = (bit_idx == IDX_W'(BYTE_W - 1));
    assign byte_done = rx_valid && last_bit;
    assign rx_byte   = {rx_bit, shreg[BYTE_W-1:1]};

    always_comb begin
        st_nxt = st;
        if (bus_reset) begin
            st_nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:    if (sel_start) st_nxt = ST_OPCODE;
                ST_OPCODE:  if (byte_done)
                                st_nxt = (rx_byte == OP_READ || rx_byte == OP_WRITE)
                                         ? ST_ADDRESS : ST_SKIP;
                ST_ADDRESS: if (byte_done) st_nxt = is_wr ? ST_WRITE : ST_READ;
                ST_READ:    st_nxt = ST_READ;
                ST_WRITE:   st_nxt = ST_WRITE;
                ST_SKIP:    st_nxt = ST_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
            addr    <= '0;
            is_wr   <= 1'b0;
        end else if (bus_reset) begin
            bit_idx <= '0;
            is_wr   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: bit_idx <= '0;
                ST_OPCODE, ST_ADDRESS, ST_WRITE: begin
                    if (rx_valid) begin
                        shreg   <= rx_byte;
                        bit_idx <= bit_idx + 1'b1;
                    end
                    if (byte_done) begin
                        if (st == ST_OPCODE)  is_wr <= (rx_byte == OP_WRITE);
                        if (st == ST_ADDRESS) addr  <= rx_byte;
                        if (st == ST_WRITE)   addr  <= addr + 1'b1;
                    end
                end
                ST_READ: begin
                    if (tx_req) begin
                        bit_idx <= bit_idx + 1'b1;
                        if (last_bit) addr <= addr + 1'b1;
                    end
                end
                ST_SKIP: ;
            endcase
        end
    end

    assign rd_active = (st == ST_READ);
    assign wr_active = (st == ST_WRITE);
    assign wr_commit = wr_active && byte_done;
    assign wr_byte   = rx_byte;
endmodule

// File: rtl/owreg_regs.sv
module owreg_regs
    import owreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] addr,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              rd_active,
    input  logic              wr_active,
    input  logic              wr_commit,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [WORD_W-1:0] cur_val,
    input  logic [WORD_W-1:0] acc_val,
    input  logic              pio_pin_in,
    output logic              tx_bit,
    output logic              sleep_en,
    output logic              opsel,
    output logic              pio_drive_low,
    output logic              acc_wr_en,
    output logic [WORD_W-1:0] acc_wr_data
);
    logic              pio_ctl;
    logic [BYTE_W-1:0] acc_stage;
    logic              hi_written;
    logic [WORD_W-1:0] snap_cur, snap_acc;
    logic              held_cur, held_acc;
    logic [WORD_W-1:0] cur_view, acc_view;
    logic [BYTE_W-1:0] rd_byte;

    assign cur_view = held_cur ? snap_cur : cur_val;
    assign acc_view = held_acc ? snap_acc : acc_val;

    always_comb begin
        rd_byte = '0;
        unique case (addr)
            A_STATUS: begin
                rd_byte[B_SLEEP] = sleep_en;
                rd_byte[B_OPSEL] = opsel;
            end
            A_FEAT:   rd_byte[B_PIO] = pio_pin_in;
            A_CUR_HI: rd_byte = cur_view[WORD_W-1:BYTE_W];
            A_CUR_LO: rd_byte = cur_view[BYTE_W-1:0];
            A_ACC_HI: rd_byte = acc_view[WORD_W-1:BYTE_W];
            A_ACC_LO: rd_byte = acc_view[BYTE_W-1:0];
            default:  rd_byte = '0;
        endcase
    end

    assign tx_bit        = rd_active ? rd_byte[bit_idx] : 1'b1;
    assign pio_drive_low = ~pio_ctl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_en    <= 1'b0;
            opsel       <= 1'b0;
            pio_ctl     <= 1'b1;
            acc_stage   <= '0;
            hi_written  <= 1'b0;
            snap_cur    <= '0;
            snap_acc    <= '0;
            held_cur    <= 1'b0;
            held_acc    <= 1'b0;
            acc_wr_en   <= 1'b0;
            acc_wr_data <= '0;
        end else begin
            acc_wr_en <= 1'b0;
            if (!wr_active) hi_written <= 1'b0;
            if (!rd_active) begin
                held_cur <= 1'b0;
                held_acc <= 1'b0;
            end else if (bit_idx == '0) begin
                if (addr == A_CUR_HI && !held_cur) begin
                    snap_cur <= cur_val;
                    held_cur <= 1'b1;
                end
                if (addr == A_ACC_HI && !held_acc) begin
                    snap_acc <= acc_val;
                    held_acc <= 1'b1;
                end
            end
            if (wr_commit) begin
                unique case (addr)
                    A_STATUS: begin
                        sleep_en <= wr_byte[B_SLEEP];
                        opsel    <= wr_byte[B_OPSEL];
                    end
                    A_FEAT:   pio_ctl <= wr_byte[B_PIO];
                    A_ACC_HI: begin
                        acc_stage  <= wr_byte;
                        hi_written <= 1'b1;
                    end
                    A_ACC_LO: begin
                        acc_wr_en   <= 1'b1;
                        acc_wr_data <= {hi_written ? acc_stage : acc_val[WORD_W-1:BYTE_W],
                                        wr_byte};
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/owreg_cmd.sv
module owreg_cmd
    import owreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              sel_start,
    input  logic              rx_valid,
    input  logic              rx_bit,
    input  logic              tx_req,
    output logic              tx_bit,
    input  logic [WORD_W-1:0] cur_val,
    input  logic [WORD_W-1:0] acc_val,
    input  logic              pio_pin_in,
    output logic              pio_drive_low,
    output logic              sleep_en,
    output logic              opsel,
    output logic              acc_wr_en,
    output logic [WORD_W-1:0] acc_wr_data
);
    logic [BYTE_W-1:0] addr;
    logic [IDX_W-1:0]  bit_idx;
    logic              rd_active, wr_active, wr_commit;
    logic [BYTE_W-1:0] wr_byte;

    owreg_seq u_seq (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .sel_start(sel_start),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_req(tx_req),
        .addr(addr), .bit_idx(bit_idx), .rd_active(rd_active),
        .wr_active(wr_active), .wr_commit(wr_commit), .wr_byte(wr_byte)
    );

    owreg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .bit_idx(bit_idx),
        .rd_active(rd_active), .wr_active(wr_active), .wr_commit(wr_commit),
        .wr_byte(wr_byte), .cur_val(cur_val), .acc_val(acc_val),
        .pio_pin_in(pio_pin_in), .tx_bit(tx_bit), .sleep_en(sleep_en),
        .opsel(opsel), .pio_drive_low(pio_drive_low), .acc_wr_en(acc_wr_en),
        .acc_wr_data(acc_wr_data)
    );
endmodule

// File: rtl/owreg_cmd_chk.sv
module owreg_cmd_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_reset,
    input logic rx_valid,
    input logic rd_active,
    input logic wr_active,
    input logic sleep_en,
    input logic opsel,
    input logic pio_drive_low,
    input logic acc_wr_en
);
    // R8
    acc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr_en |=> !acc_wr_en);

    // R8
    acc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr_en |-> $past(wr_active && rx_valid && !bus_reset));

    // R10
    reset_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !rd_active && !wr_active);

    // R1
    mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_active && wr_active));

    // R5
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({sleep_en, opsel}) |-> $past(wr_active && rx_valid && !bus_reset));

    // R6
    pio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pio_drive_low) |-> $past(wr_active && rx_valid && !bus_reset));
endmodule

bind owreg_cmd owreg_cmd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rd_active(rd_active), .wr_active(wr_active), .sleep_en(sleep_en),
    .opsel(opsel), .pio_drive_low(pio_drive_low), .acc_wr_en(acc_wr_en)
);

// File: tb/owreg_cmd_tb.sv
module owreg_cmd_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0, sel_start = 1'b0;
    logic        rx_valid = 1'b0, rx_bit = 1'b0, tx_req = 1'b0;
    logic        tx_bit;
    logic [15:0] cur_val = 16'h0000, acc_val = 16'h0000;
    logic        pio_pin_in = 1'b0;
    logic        pio_drive_low, sleep_en, opsel, acc_wr_en;
    logic [15:0] acc_wr_data;

    int n_tests = 0, n_fail = 0;
    int acc_cnt = 0;
    logic [15:0] acc_last = '0;

    always #2.5 clk = ~clk;

    owreg_cmd u_dut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .sel_start(sel_start),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_req(tx_req), .tx_bit(tx_bit),
        .cur_val(cur_val), .acc_val(acc_val), .pio_pin_in(pio_pin_in),
        .pio_drive_low(pio_drive_low), .sleep_en(sleep_en), .opsel(opsel),
        .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data)
    );

    always @(posedge clk) if (acc_wr_en) begin
        acc_cnt  <= acc_cnt + 1;
        acc_last <= acc_wr_data;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_sel();
        @(negedge clk) sel_start = 1'b1;
        @(negedge clk) sel_start = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk) bus_reset = 1'b1;
        @(negedge clk) bus_reset = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) begin rx_valid = 1'b1; rx_bit = b; end
        @(negedge clk) rx_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic get_byte(output logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) begin v[i] = tx_bit; tx_req = 1'b1; end
            @(negedge clk) tx_req = 1'b0;
        end
    endtask

    task automatic wr_bytes(input logic [7:0] a, input logic [7:0] d0,
                            input logic [7:0] d1, input int n);
        pulse_sel();
        send_byte(8'h6C);
        send_byte(a);
        if (n > 0) send_byte(d0);
        if (n > 1) send_byte(d1);
        pulse_reset();
    endtask

    task automatic t_reset();
        check("R5 reset sleep_en", sleep_en, 0);
        check("R5 reset opsel", opsel, 0);
        check("R6 reset pio released", pio_drive_low, 0);
        check("R8 reset no strobe", acc_wr_en, 0);
        check("R2 idle tx_bit", tx_bit, 1);
    endtask

    task automatic t_status();
        logic [7:0] v;
        wr_bytes(8'h01, 8'hFF, 8'h00, 1);
        check("R5 sleep_en set", sleep_en, 1);
        check("R5 opsel set", opsel, 1);
        pulse_sel(); send_byte(8'h69); send_byte(8'h01);
        get_byte(v); check("R5 status readback", v, 8'h50);
        pulse_reset();
        wr_bytes(8'h01, 8'h10, 8'h00, 1);
        check("R5 sleep_en cleared", sleep_en, 0);
        check("R5 opsel kept", opsel, 1);
    endtask

    task automatic t_pio();
        logic [7:0] v;
        wr_bytes(8'h08, 8'hBF, 8'h00, 1);
        check("R6 pio driven low", pio_drive_low, 1);
        pio_pin_in = 1'b0;
        pulse_sel(); send_byte(8'h69); send_byte(8'h08);
        get_byte(v); check("R6 read pin low", v, 8'h00);
        pulse_reset();
        pio_pin_in = 1'b1;
        wr_bytes(8'h08, 8'h40, 8'h00, 1);
        check("R6 pio released", pio_drive_low, 0);
        pulse_sel(); send_byte(8'h69); send_byte(8'h08);
        get_byte(v); check("R6 read pin high", v, 8'h40);
        pulse_reset();
    endtask

    task automatic t_snapshot();
        logic [7:0] v;
        cur_val = 16'h1234;
        pulse_sel(); send_byte(8'h69); send_byte(8'h0E);
        get_byte(v); check("R4 R7 current hi", v, 8'h12);
        cur_val = 16'h5678;
        get_byte(v); check("R4 current lo from capture", v, 8'h34);
        acc_val = 16'hA1B2;
        get_byte(v); check("R4 acc hi", v, 8'hA1);
        acc_val = 16'hC3D4;
        get_byte(v); check("R4 acc lo from capture", v, 8'hB2);
        pulse_reset();
        pulse_sel(); send_byte(8'h69); send_byte(8'h0F);
        get_byte(v); check("R4 live lo without hi", v, 8'h78);
        pulse_reset();
    endtask

    task automatic t_wrap_read();
        logic [7:0] v;
        pulse_sel(); send_byte(8'h69); send_byte(8'hFF);
        get_byte(v); check("R9 reserved FFh", v, 8'h00);
        get_byte(v); check("R3 R9 wrap to 00h", v, 8'h00);
        get_byte(v); check("R3 wrap reaches status", v, 8'h10);
        pulse_reset();
    endtask

    task automatic t_acc_write();
        int c0;
        c0 = acc_cnt;
        acc_val = 16'h9900;
        wr_bytes(8'h10, 8'hAB, 8'hCD, 2);
        check("R8 one strobe", acc_cnt - c0, 1);
        check("R8 data hi+lo", acc_last, 16'hABCD);
        wr_bytes(8'h11, 8'h5A, 8'h00, 1);
        check("R8 lo only uses live hi", acc_last, 16'h995A);
        check("R8 strobe count", acc_cnt - c0, 2);
    endtask

    task automatic t_readonly();
        logic [7:0] v;
        int c0;
        c0 = acc_cnt;
        cur_val = 16'h2468;
        wr_bytes(8'h0E, 8'hFF, 8'hFF, 2);
        pulse_sel(); send_byte(8'h69); send_byte(8'h0E);
        get_byte(v); check("R7 write ignored hi", v, 8'h24);
        get_byte(v); check("R7 write ignored lo", v, 8'h68);
        pulse_reset();
        wr_bytes(8'h20, 8'hFF, 8'hFF, 2);
        pulse_sel(); send_byte(8'h69); send_byte(8'h20);
        get_byte(v); check("R9 reserved write ignored", v, 8'h00);
        pulse_reset();
        check("R7 no acc strobe", acc_cnt - c0, 0);
    endtask

    task automatic t_partial();
        pulse_sel(); send_byte(8'h6C); send_byte(8'h01);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        pulse_reset();
        check("R10 partial byte dropped sleep", sleep_en, 0);
        check("R10 partial byte dropped opsel", opsel, 1);
    endtask

    task automatic t_bad_opcode();
        int c0;
        c0 = acc_cnt;
        pulse_sel(); send_byte(8'hAA); send_byte(8'h01); send_byte(8'h40);
        check("R1 bad opcode no status change", {sleep_en, opsel}, 2'b01);
        check("R1 bad opcode tx idle", tx_bit, 1);
        send_byte(8'h11); send_byte(8'hEE);
        check("R1 bad opcode no acc strobe", acc_cnt - c0, 0);
        pulse_reset();
    endtask

    task automatic t_wrap_write();
        wr_bytes(8'hFF, 8'h00, 8'h00, 2);
        pulse_sel(); send_byte(8'h6C); send_byte(8'hFF);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h40);
        pulse_reset();
        check("R3 write wrap to status", {sleep_en, opsel}, 2'b10);
    endtask

    task automatic t_reset_midread();
        logic [7:0] v;
        pulse_sel(); send_byte(8'h69); send_byte(8'h01);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) tx_req = 1'b1;
            @(negedge clk) tx_req = 1'b0;
        end
        pulse_reset();
        check("R10 tx idle after reset", tx_bit, 1);
        pulse_sel(); send_byte(8'h69); send_byte(8'h01);
        get_byte(v); check("R10 R2 fresh read after reset", v, 8'h40);
        pulse_reset();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_pio();
        t_snapshot();
        t_wrap_read();
        t_acc_write();
        t_readonly();
        t_partial();
        t_bad_opcode();
        t_wrap_write();
        t_reset_midread();
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule